// File: doc/BRIEF.md
# Console I/O Port Address Decoder

This block sits on the 8-bit I/O port bus of a small handheld game console's CPU. It turns each port read or write into one of three things. Ports 0x00 to 0x06 go to a local bank of system registers, and each of those registers has its own reset value and write mask. Ports 0x40 to 0xBF are mirrored onto the sound and video chips; within each of those ranges, the low address bit picks the target. Every other port is inert.

The CPU presents an address, write data and one read or write strobe per access. Read data is combinational from the address and the stored state. The strobes to the sound and video chips are single-cycle pulses in the same cycle as the CPU strobe. The downstream chips take the written byte from the shared write-data bus.

The address is sorted into a region with an enumerated type (system, misc, sound/counter, video, none). Each region has one named access behaviour, and there is no sequential state besides the register bank.

Top module: `port_space_router`

## Requirements
- R1: After synchronous active-high reset, reads of ports 0x01..0x05 return 0x7F, 0xFF, 0x00, 0xFF, 0x00, and bits 6:0 of port 0x00 read 0x40.
- R2: Bit 7 of a port 0x00 read equals the active-low start button input (pressed reads 0). Writes to port 0x00 do not change bits 6:0.
- R3: Ports 0x01, 0x02 and 0x03 store the written byte and return it on read.
- R4: Port 0x04 ignores writes and always reads 0xFF.
- R5: A write to port 0x05 stores the byte ANDed with 0xF8; reads return the stored value.
- R6: A write to port 0x06 pulses `stereo_wr` for that cycle and stores nothing. A read of port 0x06 returns 0xFF.
- R7: Ports 0x07..0x3F read 0xFF. Writes there raise no downstream strobe and change no register.
- R8: In 0x40..0x7F, an even-port read returns `vid_vcount` and an odd-port read returns `vid_hcount`. Any write there pulses `snd_wr`.
- R9: In 0x80..0xBF, an even port drives `vid_data_rd`/`vid_data_wr` and an odd port drives `vid_ctrl_rd`/`vid_ctrl_wr`. Reads in the range return `vid_rdata`.
- R10: Ports 0xC0..0xFF read 0xFF and raise no strobe on write.
- R11: Each downstream strobe is high only in a cycle where the matching CPU strobe is high. At most one downstream strobe is high at a time.
- R12: When `rd_en` and `wr_en` are both high, the write takes effect and no downstream read strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| port_addr | input | 8 | CPU port address |
| wr_data | input | 8 | CPU write data, also forwarded to downstream chips |
| rd_en | input | 1 | CPU read strobe |
| wr_en | input | 1 | CPU write strobe |
| start_n | input | 1 | Start button level, low when pressed |
| vid_hcount | input | 8 | Video horizontal counter |
| vid_vcount | input | 8 | Video vertical counter |
| vid_rdata | input | 8 | Video chip read data |
| rd_data | output | 8 | Read data to CPU |
| snd_wr | output | 1 | Sound chip write pulse |
| stereo_wr | output | 1 | Stereo-control write pulse |
| vid_data_rd | output | 1 | Video data port read pulse |
| vid_data_wr | output | 1 | Video data port write pulse |
| vid_ctrl_rd | output | 1 | Video control port read pulse |
| vid_ctrl_wr | output | 1 | Video control port write pulse |

## Verification
The assertions sample the combinational outputs at the clock edge. They therefore assume that the address, strobes and start input are stable across that edge and are not X once reset is released. The bench drives every input on the falling edge and holds it through the following rising edge. The bench also keeps `rd_en` and `wr_en` apart in its sweeps. The only exception is a directed priority step, which the strobe assertions are written to accept.

// File: rtl/psr_pkg.sv
package psr_pkg;

    typedef enum logic [2:0] {
        RGN_SYS,
        RGN_MISC,
        RGN_SND,
        RGN_VID,
        RGN_NONE
    } region_e;

    function automatic logic [7:0] sys_reset_val(input int idx);
        case (idx)
            0:       return 8'hC0;
            1:       return 8'h7F;
            2:       return 8'hFF;
            3:       return 8'h00;
            4:       return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] sys_write_mask(input int idx);
        case (idx)
            1, 2, 3: return 8'hFF;
            5:       return 8'hF8;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/psr_region.sv
module psr_region
    import psr_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter int SYS_TOP  = 'h06,
    parameter int MISC_TOP = 'h3F,
    parameter int SND_TOP  = 'h7F,
    parameter int VID_TOP  = 'hBF
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           rgn
);
    always_comb begin
        if (int'(addr) <= SYS_TOP)       rgn = RGN_SYS;
        else if (int'(addr) <= MISC_TOP) rgn = RGN_MISC;
        else if (int'(addr) <= SND_TOP)  rgn = RGN_SND;
        else if (int'(addr) <= VID_TOP)  rgn = RGN_VID;
        else                             rgn = RGN_NONE;
    end
endmodule

// File: rtl/psr_sysregs.sv
module psr_sysregs
    import psr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NREG   = 6,
    localparam int IDX_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [NREG-1:0][DATA_W-1:0] q;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam logic [DATA_W-1:0] RST  = DATA_W'(sys_reset_val(i));
        localparam logic [DATA_W-1:0] MASK = DATA_W'(sys_write_mask(i));
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= RST;
            else if (wr && (int'(idx) == i))
                q[i] <= (q[i] & ~MASK) | (wdata & MASK);
        end
    end

    always_comb begin
        rdata = '1;
        for (int i = 0; i < NREG; i++)
            if (int'(idx) == i) rdata = q[i];
    end
endmodule

// File: rtl/port_space_router.sv
module port_space_router
    import psr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int NREG   = 6,
    localparam int IDX_W = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              start_n,
    input  logic [DATA_W-1:0] vid_hcount,
    input  logic [DATA_W-1:0] vid_vcount,
    input  logic [DATA_W-1:0] vid_rdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              snd_wr,
    output logic              stereo_wr,
    output logic              vid_data_rd,
    output logic              vid_data_wr,
    output logic              vid_ctrl_rd,
    output logic              vid_ctrl_wr
);
    localparam logic [ADDR_W-1:0] STEREO_PORT = ADDR_W'(NREG);

    region_e          rgn;
    logic             odd;
    logic             rd_act;
    logic             sys_wr;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] sys_q;

    assign odd    = port_addr[0];
    assign rd_act = rd_en & ~wr_en;
    assign idx    = port_addr[IDX_W-1:0];

    psr_region #(.ADDR_W(ADDR_W)) u_region (
        .addr (port_addr),
        .rgn  (rgn)
    );

    psr_sysregs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (sys_wr),
        .idx   (idx),
        .wdata (wr_data),
        .rdata (sys_q)
    );

    // strobe generation per region
    always_comb begin
        sys_wr      = 1'b0;
        stereo_wr   = 1'b0;
        snd_wr      = 1'b0;
        vid_data_rd = 1'b0;
        vid_data_wr = 1'b0;
        vid_ctrl_rd = 1'b0;
        vid_ctrl_wr = 1'b0;
        unique case (rgn)
            RGN_SYS: begin
                if (port_addr == STEREO_PORT) stereo_wr = wr_en;
                else                          sys_wr    = wr_en;
            end
            RGN_SND: snd_wr = wr_en;
            RGN_VID: begin
                vid_data_rd = rd_act & ~odd;
                vid_data_wr = wr_en  & ~odd;
                vid_ctrl_rd = rd_act &  odd;
                vid_ctrl_wr = wr_en  &  odd;
            end
            RGN_MISC, RGN_NONE: ;
            default: ;
        endcase
    end

    // read data mux
    always_comb begin
        rd_data = '1;
        unique case (rgn)
            RGN_SYS: begin
                if (port_addr == '0)
                    rd_data = {start_n, sys_q[DATA_W-2:0]};
                else if (port_addr != STEREO_PORT)
                    rd_data = sys_q;
            end
            RGN_SND: rd_data = odd ? vid_hcount : vid_vcount;
            RGN_VID: rd_data = vid_rdata;
            RGN_MISC, RGN_NONE: rd_data = '1;
            default: rd_data = '1;
        endcase
    end
endmodule

// File: rtl/psr_checks.sv
module psr_checks (
    input logic       clk,
    input logic       rst,
    input logic [7:0] port_addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic       start_n,
    input logic [7:0] rd_data,
    input logic       snd_wr,
    input logic       stereo_wr,
    input logic       vid_data_rd,
    input logic       vid_data_wr,
    input logic       vid_ctrl_rd,
    input logic       vid_ctrl_wr
);
    a_r11_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snd_wr, stereo_wr, vid_data_rd, vid_data_wr, vid_ctrl_rd, vid_ctrl_wr}));

    a_r11_wr_needs_cpu: assert property (@(posedge clk) disable iff (rst)
        (snd_wr | stereo_wr | vid_data_wr | vid_ctrl_wr) |-> wr_en);

    a_r12_rd_blocked: assert property (@(posedge clk) disable iff (rst)
        (vid_data_rd | vid_ctrl_rd) |-> (rd_en && !wr_en));

    a_r6_stereo_port: assert property (@(posedge clk) disable iff (rst)
        stereo_wr |-> (port_addr == 8'h06));

    a_r8_snd_range: assert property (@(posedge clk) disable iff (rst)
        snd_wr |-> (port_addr[7:6] == 2'b01));

    a_r9_vid_range: assert property (@(posedge clk) disable iff (rst)
        (vid_data_rd | vid_data_wr | vid_ctrl_rd | vid_ctrl_wr) |-> (port_addr[7:6] == 2'b10));

    a_r2_start_bit: assert property (@(posedge clk) disable iff (rst)
        (port_addr == 8'h00) |-> (rd_data[7] == start_n));

    a_r5_low_clear: assert property (@(posedge clk) disable iff (rst)
        (port_addr == 8'h05) |-> (rd_data[2:0] == 3'b000));

    a_r4_fixed: assert property (@(posedge clk) disable iff (rst)
        (port_addr == 8'h04) |-> (rd_data == 8'hFF));

    a_r10_high_ff: assert property (@(posedge clk) disable iff (rst)
        (port_addr >= 8'hC0) |-> (rd_data == 8'hFF));
endmodule

bind port_space_router psr_checks u_chk (
    .clk         (clk),
    .rst         (rst),
    .port_addr   (port_addr),
    .rd_en       (rd_en),
    .wr_en       (wr_en),
    .start_n     (start_n),
    .rd_data     (rd_data),
    .snd_wr      (snd_wr),
    .stereo_wr   (stereo_wr),
    .vid_data_rd (vid_data_rd),
    .vid_data_wr (vid_data_wr),
    .vid_ctrl_rd (vid_ctrl_rd),
    .vid_ctrl_wr (vid_ctrl_wr)
);

// File: tb/port_space_router_bench.sv
module port_space_router_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] port_addr = '0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       start_n = 1'b1;
    logic [7:0] vid_hcount = '0;
    logic [7:0] vid_vcount = '0;
    logic [7:0] vid_rdata = '0;
    logic [7:0] rd_data;
    logic       snd_wr, stereo_wr, vid_data_rd, vid_data_wr, vid_ctrl_rd, vid_ctrl_wr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [7:0] m [0:5];

    always #10 clk = ~clk;

    port_space_router u_port_space_router (
        .clk(clk), .rst(rst), .port_addr(port_addr), .wr_data(wr_data),
        .rd_en(rd_en), .wr_en(wr_en), .start_n(start_n),
        .vid_hcount(vid_hcount), .vid_vcount(vid_vcount), .vid_rdata(vid_rdata),
        .rd_data(rd_data), .snd_wr(snd_wr), .stereo_wr(stereo_wr),
        .vid_data_rd(vid_data_rd), .vid_data_wr(vid_data_wr),
        .vid_ctrl_rd(vid_ctrl_rd), .vid_ctrl_wr(vid_ctrl_wr)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h (addr %02h)", tag, act, exp, port_addr);
        end
    endtask

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h00)      return "R2";
        else if (a <= 8'h03) return "R3";
        else if (a == 8'h04) return "R4";
        else if (a == 8'h05) return "R5";
        else if (a == 8'h06) return "R6";
        else if (a <= 8'h3F) return "R7";
        else if (a <= 8'h7F) return "R8";
        else if (a <= 8'hBF) return "R9";
        else                 return "R10";
    endfunction

    // {snd, stereo, vdrd, vdwr, vcrd, vcwr}
    function automatic logic [7:0] exp_strb(input logic [7:0] a, input logic rd, input logic wr);
        logic [5:0] s = '0;
        logic r = rd & ~wr;
        if (a == 8'h06 && wr) s[4] = 1'b1;
        if (a >= 8'h40 && a <= 8'h7F && wr) s[5] = 1'b1;
        if (a >= 8'h80 && a <= 8'hBF) begin
            if (a % 2 == 0) begin s[3] = r; s[2] = wr; end
            else            begin s[1] = r; s[0] = wr; end
        end
        return {2'b00, s};
    endfunction

    function automatic logic [7:0] exp_rd(input logic [7:0] a);
        if (a == 8'h00)      return {start_n, m[0][6:0]};
        else if (a <= 8'h05) return m[a[2:0]];
        else if (a <= 8'h3F) return 8'hFF;
        else if (a <= 8'h7F) return (a % 2 == 0) ? vid_vcount : vid_hcount;
        else if (a <= 8'hBF) return vid_rdata;
        else                 return 8'hFF;
    endfunction

    function automatic logic [7:0] strb_vec();
        return {2'b00, snd_wr, stereo_wr, vid_data_rd, vid_data_wr, vid_ctrl_rd, vid_ctrl_wr};
    endfunction

    task automatic access(input logic [7:0] a, input logic [7:0] d, input logic rd, input logic wr,
                          input string tag);
        @(negedge clk);
        port_addr = a; wr_data = d; rd_en = rd; wr_en = wr;
        #2;
        check(tag, strb_vec(), exp_strb(a, rd, wr));
        if (rd && !wr) check(tag, rd_data, exp_rd(a));
        if (wr) begin
            if (a >= 8'h01 && a <= 8'h03) m[a[2:0]] = d;
            else if (a == 8'h05) m[5] = d & 8'hF8;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        m[0] = 8'hC0; m[1] = 8'h7F; m[2] = 8'hFF; m[3] = 8'h00; m[4] = 8'hFF; m[5] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values, then start button both levels (R2)
        for (int a = 0; a <= 6; a++) access(8'(a), 8'h00, 1'b1, 1'b0, "R1");
        start_n = 1'b0;
        access(8'h00, 8'h00, 1'b1, 1'b0, "R2");
        check("R2", rd_data, 8'h40);
        start_n = 1'b1;

        // full write sweep, each followed by readback of system ports
        for (int a = 0; a < 256; a++) begin
            access(8'(a), 8'(a) ^ 8'h5A, 1'b0, 1'b1, tag_of(8'(a)));
            for (int p = 0; p <= 6; p++) access(8'(p), 8'h00, 1'b1, 1'b0, tag_of(8'(p)));
        end
        idle();
        #2 check("R11", strb_vec(), 8'h00);

        // distinct data patterns on the read/write registers
        for (int v = 0; v < 256; v += 37) begin
            access(8'h01, 8'(v), 1'b0, 1'b1, "R3");
            access(8'h03, ~8'(v), 1'b0, 1'b1, "R3");
            access(8'h05, 8'(v), 1'b0, 1'b1, "R5");
            access(8'h01, 8'h00, 1'b1, 1'b0, "R3");
            access(8'h03, 8'h00, 1'b1, 1'b0, "R3");
            access(8'h05, 8'h00, 1'b1, 1'b0, "R5");
        end

        // full read sweep under several counter/data patterns
        for (int k = 0; k < 3; k++) begin
            vid_hcount = 8'h11 * 8'(k + 1);
            vid_vcount = 8'hA5 ^ 8'(k * 29);
            vid_rdata  = 8'h3C + 8'(k * 71);
            start_n    = k[0];
            for (int a = 0; a < 256; a++) access(8'(a), 8'h00, 1'b1, 1'b0, tag_of(8'(a)));
        end
        idle();
        #2 check("R11", strb_vec(), 8'h00);

        // R12: simultaneous read and write
        access(8'h81, 8'h77, 1'b1, 1'b1, "R12");
        access(8'h80, 8'h66, 1'b1, 1'b1, "R12");
        access(8'h02, 8'hB4, 1'b1, 1'b1, "R12");
        access(8'h02, 8'h00, 1'b1, 1'b0, "R12");
        check("R12", rd_data, 8'hB4);
        idle();

        finish_run();
    end
endmodule